// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a register-mapped watchdog. A 32-bit down-counter, clocked by the watchdog clock, is loaded by writing a tick count to the timer register. A software write to the same register reloads the count, and that write is the keepalive. While a non-zero action is selected in the control register, the counter loses one tick per clock. When it reaches zero it stops there and the selected action takes effect.

The four actions are: nothing, a level interrupt, a level non-maskable interrupt, or a fixed-length request for a full chip reset. A reset-cause bit is kept in a flop that only the power-on reset clears. Software reads this bit after a chip reset to learn whether the watchdog caused it. Software normally loads the timer while the action is still zero and then selects the action. Selecting action zero disarms the block.

Top module: `expiry_guard`

## Requirements
- R1: After reset the control action field reads 0, the timer reads 0, and irq_gen, irq_nmi and chip_rst_req are all low.
- R2: A write to offset 0x04 loads the counter with the written value, and a read of offset 0x04 in the next cycle returns exactly that value.
- R3: A write to offset 0x00 stores bits [1:0] as the action (0 none, 1 general interrupt, 2 non-maskable interrupt, 3 chip reset). The other written bits are dropped, and bit 31 is not writable.
- R4: While the action is non-zero and the count is non-zero, the count drops by exactly one per clock. While the action is 0, the count holds.
- R5: A count of zero stays at zero until the timer is written again.
- R6: With action 1, irq_gen is high exactly while the count is zero. A timer reload or a switch to action 0 drops it.
- R7: With action 2, irq_nmi is high exactly while the count is zero. A timer reload or a switch to action 0 drops it.
- R8: With action 3, chip_rst_req goes high on the clock after the count reaches zero and stays high for exactly 16 clocks. It fires once per expiry.
- R9: Control bit 31 becomes 1 when a chip reset request is issued. rst_n does not clear it; only por_n does.
- R10: With action 0, irq_gen and irq_nmi stay low even when the count is zero.
- R11: Writes to any offset other than 0x00 and 0x04 change no state, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock; one tick per rising edge |
| rst_n | input | 1 | Active-low block reset, asserted by the chip reset |
| por_n | input | 1 | Active-low power-on reset; the only clear for the reset-cause bit |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from register state |
| irq_gen | output | 1 | General interrupt level on expiry with action 1 |
| irq_nmi | output | 1 | Non-maskable interrupt level on expiry with action 2 |
| chip_rst_req | output | 1 | Chip reset request pulse on expiry with action 3 |

## Verification
A wrong count shows up on the timer read-back in the very next cycle. It also moves the interrupt edge or the first cycle of the reset request away from the cycle predicted from the loaded value. A stuck or stale action field shows up right away as a wrong control read, or as the wrong interrupt output rising at expiry. A bad pulse counter or a bad fired latch changes the width of the reset request, or makes a second request appear within the following 40 clocks. A bad reset-cause flop shows up as bit 31 reading wrong after an rst_n pulse or a por_n pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    ACT_OFF = 2'd0,
    ACT_GEN = 2'd1,
    ACT_NMI = 2'd2,
    ACT_RST = 2'd3
  } act_e;

  localparam int CTL_OFS = 0;
  localparam int TMR_OFS = 4;

  // true when the selected action arms the counter
  function automatic logic act_armed(input act_e a);
    return a != ACT_OFF;
  endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              cause,
  output logic              tmr_wr,
  output logic              ctl_wr,
  output act_e              act,
  output logic [DATA_W-1:0] bus_rdata
);
  logic hit_ctl, hit_tmr;

  assign hit_ctl = bus_addr == ADDR_W'(CTL_OFS);
  assign hit_tmr = bus_addr == ADDR_W'(TMR_OFS);
  assign tmr_wr  = bus_wr && hit_tmr;
  assign ctl_wr  = bus_wr && hit_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act <= ACT_OFF;
    else if (ctl_wr) act <= act_e'(bus_wdata[1:0]);
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctl) begin
      bus_rdata[DATA_W-1] = cause;
      bus_rdata[1:0]      = act;
    end else if (hit_tmr) begin
      bus_rdata[CNT_W-1:0] = count;
    end
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic             cnt_zero
);
  // saturating one-tick step; a load always wins
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic ld,
                                            input logic [CNT_W-1:0] v,
                                            input logic en);
    if (ld)                 return v;
    else if (en && cur != 0) return cur - 1'b1;
    else                    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= step(count, load, load_val, run);
  end

  assign cnt_zero = count == '0;
endmodule

// File: rtl/wdg_action.sv
module wdg_action
  import wdg_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  act_e act,
  input  logic cnt_zero,
  input  logic rearm,
  output logic expired,
  output logic fire,
  output logic irq_gen,
  output logic irq_nmi,
  output logic chip_rst_req,
  output logic cause
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pulse_cnt;
  logic          fired;

  assign expired = cnt_zero && act_armed(act);
  assign irq_gen = expired && act == ACT_GEN;
  assign irq_nmi = expired && act == ACT_NMI;
  assign fire    = expired && act == ACT_RST && !fired && !rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
      fired     <= 1'b0;
    end else begin
      if (fire)                pulse_cnt <= PW'(PULSE_LEN);
      else if (pulse_cnt != 0) pulse_cnt <= pulse_cnt - 1'b1;
      if (rearm)               fired <= 1'b0;
      else if (fire)           fired <= 1'b1;
    end
  end

  assign chip_rst_req = pulse_cnt != 0;

  // survives the chip reset; only power-on clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    cause <= 1'b0;
    else if (fire) cause <= 1'b1;
  end
endmodule

// File: rtl/expiry_guard.sv
module expiry_guard
  import wdg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_gen,
  output logic              irq_nmi,
  output logic              chip_rst_req
);
  act_e             act;
  logic             tmr_wr, ctl_wr, cnt_zero, expired, fire, cause;
  logic [CNT_W-1:0] count;

  wdg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count(count), .cause(cause),
    .tmr_wr(tmr_wr), .ctl_wr(ctl_wr), .act(act), .bus_rdata(bus_rdata)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(tmr_wr), .load_val(bus_wdata[CNT_W-1:0]),
    .run(act_armed(act)), .count(count), .cnt_zero(cnt_zero)
  );

  wdg_action #(.PULSE_LEN(PULSE_LEN)) u_act (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .act(act), .cnt_zero(cnt_zero),
    .rearm(tmr_wr || ctl_wr), .expired(expired), .fire(fire),
    .irq_gen(irq_gen), .irq_nmi(irq_nmi), .chip_rst_req(chip_rst_req),
    .cause(cause)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input act_e              act,
  input logic [CNT_W-1:0]  count,
  input logic              tmr_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              cnt_zero,
  input logic              irq_gen,
  input logic              irq_nmi,
  input logic              chip_rst_req,
  input logic              cause
);
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> count == $past(bus_wdata[CNT_W-1:0]));
  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act != ACT_OFF && !cnt_zero && !tmr_wr) |=> count == $past(count) - 1'b1);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_OFF && !tmr_wr) |=> $stable(count));
  assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !tmr_wr) |=> count == '0);
  assert_gen_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gen |-> (count == '0 && act == ACT_GEN));
  assert_nmi_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nmi |-> (count == '0 && act == ACT_NMI));
  assert_cause_set_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    chip_rst_req |-> cause);
  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_OFF |-> !irq_gen && !irq_nmi);
endmodule

bind expiry_guard wdg_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .act(act), .count(count),
  .tmr_wr(tmr_wr), .bus_wdata(bus_wdata), .cnt_zero(cnt_zero),
  .irq_gen(irq_gen), .irq_nmi(irq_nmi), .chip_rst_req(chip_rst_req),
  .cause(cause)
);

// File: tb/expiry_guard_bench.sv
module expiry_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n, por_n, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_gen, irq_nmi, chip_rst_req;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  expiry_guard u_expiry_guard (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_gen(irq_gen), .irq_nmi(irq_nmi), .chip_rst_req(chip_rst_req)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd4, v); check("R1 timer", v, 32'h0);
    check("R1 outputs", {29'd0, irq_gen, irq_nmi, chip_rst_req}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(3'd4, 32'hDEAD_BEEF); rd(3'd4, v); check("R2 readback", v, 32'hDEAD_BEEF);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); check("R2 max", v, 32'hFFFF_FFFF);
    wr(3'd0, 32'h8000_7FF2); rd(3'd0, v); check("R3 ctrl mask", v, 32'h0000_0002);
    wr(3'd0, 32'h0); rd(3'd0, v); check("R3 ctrl zero", v, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(3'd4, 32'd9); ticks(5); rd(3'd4, v); check("R4 hold when off", v, 32'd9);
    wr(3'd4, 32'd10); wr(3'd0, 32'd1);
    rd(3'd4, v); check("R4 start", v, 32'd10);
    ticks(3); rd(3'd4, v); check("R4 minus three", v, 32'd7);
    ticks(7); rd(3'd4, v); check("R5 reached zero", v, 32'd0);
    ticks(4); rd(3'd4, v); check("R5 holds zero", v, 32'd0);
    wr(3'd0, 32'd0);
  endtask

  task automatic t_gen;
    wr(3'd4, 32'd5); wr(3'd0, 32'd1);
    ticks(4); check("R6 before expiry", {31'd0, irq_gen}, 32'd0);
    ticks(1); check("R6 at expiry", {31'd0, irq_gen}, 32'd1);
    check("R6 nmi quiet", {31'd0, irq_nmi}, 32'd0);
    wr(3'd4, 32'd20); check("R6 reload clears", {31'd0, irq_gen}, 32'd0);
    ticks(20); check("R6 again", {31'd0, irq_gen}, 32'd1);
    wr(3'd0, 32'd0); check("R10 off clears gen", {31'd0, irq_gen}, 32'd0);
    ticks(3); check("R10 off zero count", {30'd0, irq_gen, irq_nmi}, 32'd0);
  endtask

  task automatic t_nmi;
    wr(3'd4, 32'd2); wr(3'd0, 32'd2);
    ticks(1); check("R7 before", {31'd0, irq_nmi}, 32'd0);
    ticks(1); check("R7 at expiry", {31'd0, irq_nmi}, 32'd1);
    check("R7 gen quiet", {31'd0, irq_gen}, 32'd0);
    wr(3'd0, 32'd0); check("R7 off clears", {31'd0, irq_nmi}, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(3'd4, 32'd33);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd6, 32'h1234_5678);
    rd(3'd0, v); check("R11 ctrl untouched", v, 32'h0);
    rd(3'd4, v); check("R11 timer untouched", v, 32'd33);
    rd(3'd6, v); check("R11 read zero", v, 32'h0);
  endtask

  task automatic t_reset_req;
    logic [31:0] v;
    int first = -1;
    int high = 0;
    rd(3'd0, v); check("R9 clear before", v & 32'h8000_0000, 32'h0);
    wr(3'd4, 32'd3); wr(3'd0, 32'd3);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (chip_rst_req) begin
        high++;
        if (first < 0) first = k;
      end
    end
    check("R8 first cycle", first, 4);
    check("R8 width once", high, 16);
    rd(3'd0, v); check("R9 set", v, 32'h8000_0003);
    @(negedge clk); rst_n = 1'b0; ticks(2); rst_n = 1'b1;
    rd(3'd0, v); check("R9 survives rst_n", v, 32'h8000_0000);
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0; ticks(2); por_n = 1'b1; rst_n = 1'b1;
    rd(3'd0, v); check("R9 por clears", v, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ticks(3);
    rst_n = 1'b1; por_n = 1'b1;
    t_reset();
    t_regs();
    t_count();
    t_gen();
    t_nmi();
    t_unmapped();
    t_reset_req();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule